// File: doc/BRIEF.md
# Shared Prescaler Tick Generator

This block turns one input clock into five independent count-enable strobes, one for each timer channel. Two prescalers set the coarse rate. Each prescaler serves a group of channels: the first group is channels 0 and 1, the second is channels 2, 3 and 4. Each channel then divides its group's rate by a power of two that it selects itself. Every output is a single-cycle enable in the input clock domain. Downstream counters use it as a qualifier, so no derived clock is ever created.

The block holds two configuration words, each with its own write strobe. The prescaler word carries the two 8-bit prescaler values. The divider word carries one 4-bit select field per channel. A write to either word restarts every internal counter from zero, so the new ratios take effect from a known phase. The current contents of both words are brought out so that they can be read back.

Top module: `pwm_tick_gen`

## Requirements
- R1: After reset, the prescaler word reads 0x0101 and the divider word reads 0.
- R2: A cycle with `presc_wr` high loads `presc_data`, and a cycle with `divsel_wr` high loads `divsel_data`. Each new value appears on the matching readback output in the next cycle.
- R3: Channels 0 and 1 take their prescaler value from bits [7:0] of the prescaler word. Channels 2, 3 and 4 take theirs from bits [15:8].
- R4: Channel n takes its select value from bits [4n+3:4n] of the divider word. It ticks once every (prescaler + 1) × 2^select input cycles.
- R5: A select value greater than 4 behaves exactly as a select value of 4.
- R6: No tick is produced in a cycle that writes either word. Count the cycle after the write as cycle 0. A channel whose period is P then ticks first in cycle P−1, and every P cycles after that.
- R7: Each tick lasts one cycle, except when the period is 1 (prescaler 0 and select 0). In that case the channel ticks in every cycle that does not write a word.
- R8: Count the first cycle after reset is released as cycle 0. Each channel then ticks first in cycle P−1, where P is the period given by the reset values (2 for every channel).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_wr | input | 1 | Write strobe for the prescaler word |
| presc_data | input | 16 | New prescaler word (bits [7:0] for group 0, bits [15:8] for group 1) |
| divsel_wr | input | 1 | Write strobe for the divider word |
| divsel_data | input | 20 | New divider word (4 bits per channel) |
| presc_q | output | 16 | Current prescaler word |
| divsel_q | output | 20 | Current divider word |
| tick_o | output | 5 | One count-enable strobe per channel |

## Verification
A wrong prescaler count shows at the ports as a shifted or stretched tick on every channel of its group, within one prescaler period. A wrong divider count disturbs only its own channel, within one full channel period of at most 4096 cycles. A missed restart after a write shows as a first tick that does not land in cycle P−1 after the write. Because every one of these faults moves a tick edge, a model that predicts each channel's output in every cycle catches the fault in the first cycle where a tick appears or goes missing.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  parameter int SEL_W = 4;

  // Effective power-of-two exponent after the ceiling is applied.
  function automatic int clamp_sel(input int sel, input int ceiling);
    return (sel > ceiling) ? ceiling : sel;
  endfunction

  // Prescaler group feeding a given channel.
  function automatic int group_of(input int ch, input int first_group_size);
    return (ch < first_group_size) ? 0 : 1;
  endfunction

  // Terminal value of a divider that emits once per 2^sel carries.
  function automatic int div_last(input int sel);
    return (1 << sel) - 1;
  endfunction
endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs #(
  parameter int PW   = 8,
  parameter int NGRP = 2,
  parameter int NCH  = 5,
  parameter int SW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 presc_wr,
  input  logic [NGRP*PW-1:0]   presc_data,
  input  logic                 divsel_wr,
  input  logic [NCH*SW-1:0]    divsel_data,
  output logic [NGRP*PW-1:0]   presc_word,
  output logic [NCH*SW-1:0]    divsel_word,
  output logic                 restart
);
  localparam logic [NGRP*PW-1:0] PRESC_RST = {NGRP{PW'(1)}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_word  <= PRESC_RST;
      divsel_word <= '0;
    end else begin
      if (presc_wr)  presc_word  <= presc_data;
      if (divsel_wr) divsel_word <= divsel_data;
    end
  end

  assign restart = presc_wr | divsel_wr;
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [PW-1:0] limit,
  output logic          carry
);
  logic [PW-1:0] cnt;

  assign carry = !restart && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (carry)   cnt <= '0;
    else              cnt <= cnt + PW'(1);
  end
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import pwm_tick_pkg::*;
#(
  parameter int SW     = 4,
  parameter int MAXSEL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          carry,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  localparam int CW = (MAXSEL > 0) ? MAXSEL : 1;

  logic [CW-1:0] dcnt;
  logic [CW-1:0] last;

  assign last = CW'(div_last(clamp_sel(int'(sel), MAXSEL)));
  assign tick = carry && (dcnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)       dcnt <= '0;
    else if (restart) dcnt <= '0;
    else if (carry)   dcnt <= tick ? '0 : dcnt + CW'(1);
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_tick_pkg::*;
#(
  parameter int PW     = 8,
  parameter int NCH    = 5,
  parameter int GRP0_N = 2,
  parameter int SW     = SEL_W,
  parameter int MAXSEL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              presc_wr,
  input  logic [2*PW-1:0]   presc_data,
  input  logic              divsel_wr,
  input  logic [NCH*SW-1:0] divsel_data,
  output logic [2*PW-1:0]   presc_q,
  output logic [NCH*SW-1:0] divsel_q,
  output logic [NCH-1:0]    tick_o
);
  localparam int NGRP = 2;

  logic            restart;
  logic [NGRP-1:0] psc_carry;

  tick_cfg_regs #(.PW(PW), .NGRP(NGRP), .NCH(NCH), .SW(SW)) i_cfg (
    .clk(clk), .rst_n(rst_n),
    .presc_wr(presc_wr), .presc_data(presc_data),
    .divsel_wr(divsel_wr), .divsel_data(divsel_data),
    .presc_word(presc_q), .divsel_word(divsel_q),
    .restart(restart)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_psc
    tick_prescaler #(.PW(PW)) i_psc (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .limit(presc_q[g*PW +: PW]), .carry(psc_carry[g])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int GRP = group_of(c, GRP0_N);
    tick_divider #(.SW(SW), .MAXSEL(MAXSEL)) i_div (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .carry(psc_carry[GRP]), .sel(divsel_q[c*SW +: SW]),
      .tick(tick_o[c])
    );
  end
endmodule

// File: rtl/pwm_tick_chk.sv
module pwm_tick_chk
  import pwm_tick_pkg::*;
#(
  parameter int PW     = 8,
  parameter int NCH    = 5,
  parameter int GRP0_N = 2,
  parameter int SW     = 4,
  parameter int MAXSEL = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              presc_wr,
  input logic [2*PW-1:0]   presc_data,
  input logic              divsel_wr,
  input logic [NCH*SW-1:0] divsel_data,
  input logic [2*PW-1:0]   presc_q,
  input logic [NCH*SW-1:0] divsel_q,
  input logic [NCH-1:0]    tick_o,
  input logic [1:0]        carry
);
  for (genvar g = 0; g < 2; g++) begin : g_grp
    logic [PW-1:0] gap;
    always_ff @(posedge clk) begin
      if (!rst_n || presc_wr || divsel_wr || carry[g]) gap <= '0;
      else gap <= gap + PW'(1);
    end
    // R3: carry of each group comes exactly every (limit+1) cycles
    p_carry_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      carry[g] |-> (gap == presc_q[g*PW +: PW]));
    // R4: the spacing counter never passes the limit
    p_gap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gap <= presc_q[g*PW +: PW]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam int GRP = group_of(c, GRP0_N);
    // R4: a tick only coincides with its group's carry
    p_tick_on_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o[c] |-> carry[GRP]);
    // R7: select 0 passes every carry straight through
    p_sel0_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clamp_sel(int'(divsel_q[c*SW +: SW]), MAXSEL) == 0) |-> (tick_o[c] == carry[GRP]));
  end

  // R6: writes silence all ticks
  p_quiet_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_wr || divsel_wr) |-> (tick_o == '0));
  // R2: written words appear one cycle later
  p_presc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    presc_wr |=> (presc_q == $past(presc_data)));
  p_divsel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    divsel_wr |=> (divsel_q == $past(divsel_data)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!presc_wr && !divsel_wr) |=> ($stable(presc_q) && $stable(divsel_q)));
endmodule

bind pwm_tick_gen pwm_tick_chk #(
  .PW(PW), .NCH(NCH), .GRP0_N(GRP0_N), .SW(SW), .MAXSEL(MAXSEL)
) i_chk (
  .clk(clk), .rst_n(rst_n),
  .presc_wr(presc_wr), .presc_data(presc_data),
  .divsel_wr(divsel_wr), .divsel_data(divsel_data),
  .presc_q(presc_q), .divsel_q(divsel_q),
  .tick_o(tick_o), .carry(psc_carry)
);

// File: tb/test_pwm_tick_gen.sv
`timescale 1ns/1ps
module test_pwm_tick_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        presc_wr = 0;
  logic [15:0] presc_data = 0;
  logic        divsel_wr = 0;
  logic [19:0] divsel_data = 0;
  logic [15:0] presc_q;
  logic [19:0] divsel_q;
  logic [4:0]  tick_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string req = "R8";

  // reference state
  logic [15:0] m_presc = 16'h0101;
  logic [19:0] m_sel = 0;
  int n = 0;

  always #2 clk = ~clk;

  pwm_tick_gen i_pwm_tick_gen (
    .clk(clk), .rst_n(rst_n),
    .presc_wr(presc_wr), .presc_data(presc_data),
    .divsel_wr(divsel_wr), .divsel_data(divsel_data),
    .presc_q(presc_q), .divsel_q(divsel_q), .tick_o(tick_o)
  );

  function automatic logic [4:0] expect_ticks(input logic [15:0] pw, input logic [19:0] sw,
                                              input int cyc, input bit wr);
    logic [4:0] r;
    for (int ch = 0; ch < 5; ch++) begin
      int p, s, per;
      p = (ch < 2) ? int'(pw[7:0]) : int'(pw[15:8]);
      s = int'(sw[ch*4 +: 4]);
      if (s > 4) s = 4;
      per = (p + 1) * (2 ** s);
      r[ch] = !wr && (((cyc + 1) % per) == 0);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_presc <= 16'h0101; m_sel <= 0; n <= 0;
    end else if (presc_wr || divsel_wr) begin
      if (presc_wr) m_presc <= presc_data;
      if (divsel_wr) m_sel <= divsel_data;
      n <= 0;
    end else n <= n + 1;
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic [4:0] e;
      e = expect_ticks(m_presc, m_sel, n, presc_wr || divsel_wr);
      checks++;
      if (tick_o !== e) begin
        failures++;
        $display("FAIL %s tick cyc=%0d actual=%b expected=%b", req, n, tick_o, e);
      end
      checks++;
      if (presc_q !== m_presc || divsel_q !== m_sel) begin
        failures++;
        $display("FAIL R2 words actual=%h/%h expected=%h/%h", presc_q, divsel_q, m_presc, m_sel);
      end
    end
  end

  task automatic run(input int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic wr(input bit wp, input logic [15:0] dp, input bit ws, input logic [19:0] ds);
    @(negedge clk);
    presc_wr = wp; presc_data = dp; divsel_wr = ws; divsel_data = ds;
    @(negedge clk);
    presc_wr = 0; divsel_wr = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values of both words
    checks++;
    if (presc_q !== 16'h0101 || divsel_q !== 20'h0) begin
      failures++;
      $display("FAIL R1 actual=%h/%h expected=0101/00000", presc_q, divsel_q);
    end
    rst_n = 1;
    req = "R8"; run(40);
    req = "R3"; wr(1, 16'h0002, 0, 0); run(60);
    req = "R4"; wr(0, 0, 1, 20'h04321); run(200);
    req = "R3"; wr(1, 16'h0301, 0, 0); run(300);
    req = "R5"; wr(0, 0, 1, 20'h794F5); run(400);
    req = "R6"; run(13); wr(0, 0, 1, 20'h794F5); run(100);
    wr(1, 16'h0104, 1, 20'h10203); run(200);
    req = "R7"; wr(1, 16'h0000, 1, 20'h00010); run(50);
    req = "R6"; wr(1, 16'h0000, 0, 0); wr(0, 0, 1, 20'h00000); run(30);
    req = "R4"; wr(1, 16'hFF05, 1, 20'h30402); run(4200);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule